// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a timer that produces one pulse-width-modulated output. A free-running up-counter runs from zero up to a programmed period value and then returns to zero. The output is driven by comparing the counter with a compare value. Software programs the period and compare through a small register interface that accepts 16-bit and 32-bit accesses. A control word switches on PWM mode, starts or stops the counter and picks the output polarity.

Each of the period and compare values exists twice: an active copy that drives the counter and the comparison, and a staging copy. Writing a staging copy while the timer runs leaves the current period untouched. The active copies take the staged values on the clock edge where the counter wraps to zero, so a period is never cut short. Writing an active copy directly is meant for setup while stopped, and it fills the matching staging copy too.

Top module: `aux_pwm_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the counter, the active and staging period and compare values and the control word, so the output is low and every register reads 0.
- R2: Register words sit at these byte offsets: counter 0x00 (read-only), active period 0x08, active compare 0x0C, staged period 0x10, staged compare 0x14, and control in the upper half-word of 0x28, i.e. at 0x2A. A 32-bit access needs an offset aligned to 4. A 16-bit access needs an even offset and reaches the low half at offset bit 1 = 0 and the high half at bit 1 = 1, with read data zero-extended. Staging registers read back the last value written.
- R3: A write to the active period or active compare also loads the same resulting value into the matching staging register.
- R4: The counter advances only while control bit 4 (run) is 1. While it is 0 the counter holds its value.
- R5: While running, the counter steps by one per clock until it equals or exceeds the active period, and on the next edge it becomes 0. A period value P therefore gives P+1 clocks per PWM cycle.
- R6: On the wrap edge the active period and compare take the staging values. At any other time a write to a staging register leaves the active values unchanged.
- R7: While control bit 9 (PWM mode) is 0, the output is low regardless of the counter.
- R8: With PWM mode on and control bit 10 clear, the output is high while counter < active compare and low otherwise. A compare of 0 gives a constant low and a compare above the period gives a constant high.
- R9: With control bit 10 set, the output is the inverse of the R8 level, so the compare value sets the low time.
- R10: Control bits 7:6 are stored and read back but have no effect on the counter or the output.
- R11: Period 1 with compare 1 is a legal minimum: the output alternates high and low on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data (a 16-bit write uses bits 15:0) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The bench writes staged values in the middle of a running period and checks the output edge by edge. A design that loaded them at once would shorten that period, and one that never loaded them would keep the old pattern. It drives compare values of zero and above the period, and the minimum period of 1. An off-by-one in the wrap test or the comparison would stretch the cycle or move the falling edge. It also checks that active-register writes fill the staging copy, which a design would miss if the next wrap brought back a stale staging value. It checks that the counter freezes when run is cleared and that the output drops when PWM mode is off even though the counter keeps going.

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_wide,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);

  localparam logic [3:0] W_CNT = 4'd0;
  localparam logic [3:0] W_PER = 4'd2;
  localparam logic [3:0] W_CMP = 4'd3;
  localparam logic [3:0] W_PSH = 4'd4;
  localparam logic [3:0] W_CSH = 4'd5;
  localparam logic [3:0] W_CTL = 4'd10;
  localparam int B_RUN   = 4;
  localparam int B_MODE  = 9;
  localparam int B_POLLO = 10;

  logic [31:0] cnt_q, per_q, cmp_q, per_sh_q, cmp_sh_q;
  logic [15:0] ctrl_q;
  logic [31:0] word;

  wire [3:0]  widx    = bus_addr[5:2];
  wire        aligned = ~bus_addr[0] & ~(bus_wide & bus_addr[1]);
  wire        we      = bus_wr & aligned;
  wire [31:0] wmask   = bus_wide ? 32'hFFFF_FFFF : (bus_addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF);
  wire [31:0] wlane   = bus_wide ? bus_wdata : {2{bus_wdata[15:0]}};
  wire [15:0] ctl_new = bus_wide ? bus_wdata[31:16] : (bus_addr[1] ? bus_wdata[15:0] : ctrl_q);

  wire run  = ctrl_q[B_RUN];
  wire wrap = run && (cnt_q >= per_q);

  wire [31:0] per_m = (per_q & ~wmask) | (wlane & wmask);
  wire [31:0] cmp_m = (cmp_q & ~wmask) | (wlane & wmask);
  wire [31:0] psh_m = (per_sh_q & ~wmask) | (wlane & wmask);
  wire [31:0] csh_m = (cmp_sh_q & ~wmask) | (wlane & wmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      per_q    <= '0;
      cmp_q    <= '0;
      per_sh_q <= '0;
      cmp_sh_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (run) cnt_q <= wrap ? '0 : cnt_q + 32'd1;
      if (wrap) begin
        per_q <= per_sh_q;
        cmp_q <= cmp_sh_q;
      end
      if (we) begin
        case (widx)
          W_PER: begin per_q <= per_m; per_sh_q <= per_m; end
          W_CMP: begin cmp_q <= cmp_m; cmp_sh_q <= cmp_m; end
          W_PSH: per_sh_q <= psh_m;
          W_CSH: cmp_sh_q <= csh_m;
          W_CTL: ctrl_q <= ctl_new;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      W_CNT:   word = cnt_q;
      W_PER:   word = per_q;
      W_CMP:   word = cmp_q;
      W_PSH:   word = per_sh_q;
      W_CSH:   word = cmp_sh_q;
      W_CTL:   word = {ctrl_q, 16'h0000};
      default: word = '0;
    endcase
    if (!aligned)      bus_rdata = '0;
    else if (bus_wide) bus_rdata = word;
    else               bus_rdata = {16'h0000, bus_addr[1] ? word[31:16] : word[15:0]};
  end

  assign pwm_out = ctrl_q[B_MODE] & ((cnt_q < cmp_q) ^ ctrl_q[B_POLLO]);

endmodule

module aux_pwm_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic        pwm_out,
  input logic [31:0] cnt,
  input logic [31:0] per,
  input logic [31:0] cmp,
  input logic [31:0] per_sh,
  input logic [31:0] cmp_sh,
  input logic [15:0] ctrl
);

  wire act_wr = bus_wr && (bus_addr[5:2] == 4'd2 || bus_addr[5:2] == 4'd3);
  wire at_end = ctrl[4] && (cnt >= per);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == 32'd0 && ctrl == 16'd0 && !pwm_out));

  a_r4_counter_holds: assert property (@(posedge clk) disable iff (rst)
    !ctrl[4] |=> $stable(cnt));

  a_r5_counter_steps: assert property (@(posedge clk) disable iff (rst)
    (ctrl[4] && cnt < per) |=> cnt == $past(cnt) + 32'd1);

  a_r5_counter_wraps: assert property (@(posedge clk) disable iff (rst)
    at_end |=> cnt == 32'd0);

  a_r6_active_steady: assert property (@(posedge clk) disable iff (rst)
    (!at_end && !act_wr) |=> ($stable(per) && $stable(cmp)));

  a_r6_shadow_loaded: assert property (@(posedge clk) disable iff (rst)
    (at_end && !act_wr) |=> (per == $past(per_sh) && cmp == $past(cmp_sh)));

  a_r7_off_low: assert property (@(posedge clk) disable iff (rst)
    !ctrl[9] |-> !pwm_out);

  a_r8_zero_compare: assert property (@(posedge clk) disable iff (rst)
    (ctrl[9] && cmp == 32'd0) |-> pwm_out == ctrl[10]);

endmodule

bind aux_pwm_timer aux_pwm_timer_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .pwm_out(pwm_out),
  .cnt(cnt_q), .per(per_q), .cmp(cmp_q), .per_sh(per_sh_q), .cmp_sh(cmp_sh_q),
  .ctrl(ctrl_q)
);

// File: tb/aux_pwm_timer_tb.sv
module aux_pwm_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  aux_pwm_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  logic [31:0] m_cnt, m_per, m_cmp, m_sper, m_scmp;
  logic [15:0] m_ctl;

  function automatic logic [31:0] put(input logic [31:0] old, input logic wide,
                                      input logic hi, input logic [31:0] d);
    if (wide) return d;
    if (hi)   return {d[15:0], old[15:0]};
    return {old[31:16], d[15:0]};
  endfunction

  function automatic logic exp_out();
    if (!m_ctl[9]) return 1'b0;
    return (m_cnt < m_cmp) ^ m_ctl[10];
  endfunction

  task automatic note(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic wide, input logic [5:0] a, input logic [31:0] d);
    logic [31:0] o_per, o_cmp;
    bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    o_per = m_per; o_cmp = m_cmp;
    if (m_ctl[4]) begin
      if (m_cnt >= m_per) begin m_cnt = 0; m_per = m_sper; m_cmp = m_scmp; end
      else m_cnt = m_cnt + 1;
    end
    if (wr && !a[0] && !(wide && a[1])) begin
      case (a[5:2])
        4'd2: begin m_per = put(o_per, wide, a[1], d); m_sper = m_per; end
        4'd3: begin m_cmp = put(o_cmp, wide, a[1], d); m_scmp = m_cmp; end
        4'd4: m_sper = put(m_sper, wide, a[1], d);
        4'd5: m_scmp = put(m_scmp, wide, a[1], d);
        4'd10: if (wide) m_ctl = d[31:16]; else if (a[1]) m_ctl = d[15:0];
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
    note(cur_req, "pwm_out", {31'b0, pwm_out}, {31'b0, exp_out()});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 6'h00, 32'h0);
  endtask

  task automatic rd(input string req, input logic wide, input logic [5:0] a, input logic [31:0] exp);
    bus_wr = 1'b0; bus_wide = wide; bus_addr = a;
    #1;
    note(req, $sformatf("read @%0h", a), bus_rdata, exp);
  endtask

  task automatic do_reset();
    cur_req = "R1";
    rst = 1'b1;
    @(posedge clk);
    m_cnt = 0; m_per = 0; m_cmp = 0; m_sper = 0; m_scmp = 0; m_ctl = 0;
    @(negedge clk);
    rst = 1'b0;
    note("R1", "pwm_out after reset", {31'b0, pwm_out}, 32'h0);
  endtask

  task automatic t_reset();
    do_reset();
    rd("R1", 1'b1, 6'h00, 32'h0);
    rd("R1", 1'b1, 6'h08, 32'h0);
    rd("R1", 1'b1, 6'h0C, 32'h0);
    rd("R1", 1'b1, 6'h10, 32'h0);
    rd("R1", 1'b1, 6'h14, 32'h0);
    rd("R1", 1'b0, 6'h2A, 32'h0);
  endtask

  task automatic t_regs();
    do_reset();
    cur_req = "R2";
    cyc(1'b1, 1'b1, 6'h10, 32'h1234_5678);
    rd("R2", 1'b1, 6'h10, 32'h1234_5678);
    rd("R2", 1'b0, 6'h12, 32'h0000_1234);
    rd("R2", 1'b0, 6'h10, 32'h0000_5678);
    cyc(1'b1, 1'b0, 6'h16, 32'h0000_BEEF);
    rd("R2", 1'b1, 6'h14, 32'hBEEF_0000);
    rd("R2", 1'b1, 6'h08, 32'h0);
    cur_req = "R3";
    cyc(1'b1, 1'b1, 6'h08, 32'h0000_0055);
    rd("R3", 1'b1, 6'h08, 32'h0000_0055);
    rd("R3", 1'b1, 6'h10, 32'h0000_0055);
    cyc(1'b1, 1'b0, 6'h0E, 32'h0000_0007);
    rd("R3", 1'b1, 6'h14, 32'h0007_0000);
    cur_req = "R10";
    cyc(1'b1, 1'b0, 6'h2A, 32'h0000_00C0);
    rd("R10", 1'b0, 6'h2A, 32'h0000_00C0);
    rd("R10", 1'b1, 6'h28, 32'h00C0_0000);
  endtask

  task automatic t_run_normal();
    do_reset();
    cur_req = "R8";
    cyc(1'b1, 1'b1, 6'h08, 32'd4);
    cyc(1'b1, 1'b1, 6'h0C, 32'd2);
    cur_req = "R5";
    cyc(1'b1, 1'b0, 6'h2A, 32'h0210);
    idle(13);
    rd("R5", 1'b1, 6'h00, m_cnt);
    cur_req = "R4";
    cyc(1'b1, 1'b0, 6'h2A, 32'h0200);
    idle(4);
    rd("R4", 1'b1, 6'h00, m_cnt);
    rd("R4", 1'b1, 6'h00, 32'd4);
  endtask

  task automatic t_shadow();
    do_reset();
    cur_req = "R6";
    cyc(1'b1, 1'b1, 6'h08, 32'd5);
    cyc(1'b1, 1'b1, 6'h0C, 32'd3);
    cyc(1'b1, 1'b0, 6'h2A, 32'h0210);
    idle(1);
    cyc(1'b1, 1'b1, 6'h10, 32'd2);
    cyc(1'b1, 1'b1, 6'h14, 32'd1);
    rd("R6", 1'b1, 6'h08, 32'd5);
    rd("R6", 1'b1, 6'h0C, 32'd3);
    rd("R6", 1'b1, 6'h10, 32'd2);
    idle(2);
    rd("R6", 1'b1, 6'h08, 32'd5);
    idle(10);
    rd("R6", 1'b1, 6'h08, 32'd2);
    rd("R6", 1'b1, 6'h0C, 32'd1);
  endtask

  task automatic t_polarity();
    do_reset();
    cur_req = "R9";
    cyc(1'b1, 1'b1, 6'h08, 32'd3);
    cyc(1'b1, 1'b1, 6'h0C, 32'd1);
    cyc(1'b1, 1'b0, 6'h2A, 32'h0610);
    idle(9);
    cur_req = "R7";
    cyc(1'b1, 1'b0, 6'h2A, 32'h0410);
    idle(6);
    note("R7", "pwm_out mode off", {31'b0, pwm_out}, 32'h0);
  endtask

  task automatic t_extremes();
    do_reset();
    cur_req = "R8";
    cyc(1'b1, 1'b1, 6'h08, 32'd3);
    cyc(1'b1, 1'b1, 6'h0C, 32'd0);
    cyc(1'b1, 1'b0, 6'h2A, 32'h0210);
    idle(6);
    note("R8", "compare 0 low", {31'b0, pwm_out}, 32'h0);
    cyc(1'b1, 1'b1, 6'h0C, 32'd9);
    idle(6);
    note("R8", "compare above period high", {31'b0, pwm_out}, 32'h1);
  endtask

  task automatic t_minimum();
    do_reset();
    cur_req = "R11";
    cyc(1'b1, 1'b1, 6'h08, 32'd1);
    cyc(1'b1, 1'b1, 6'h0C, 32'd1);
    cyc(1'b1, 1'b0, 6'h2A, 32'h02D0);
    note("R11", "first level", {31'b0, pwm_out}, 32'h1);
    idle(1);
    note("R11", "second level", {31'b0, pwm_out}, 32'h0);
    cur_req = "R10";
    idle(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_regs();
    t_run_normal();
    t_shadow();
    t_polarity();
    t_extremes();
    t_minimum();
    finish_run();
  end

endmodule